// File: doc/BRIEF.md
# Trailing field assembler

This block gathers the bytes that follow an instruction's opcode and addressing byte: an optional address displacement and an optional immediate operand. An upstream decoder pulses `start_i` with the lengths it has worked out, the operation width and an I/O flag. The block then accepts one byte per cycle over a valid/ready pair and reports how many bytes it still needs. When the last byte arrives it presents a signed 16-bit displacement and a 16-bit operand, and raises a one-cycle completion pulse.

The displacement bytes come first on the stream and the operand bytes after them. Every multi-byte field is least-significant byte first. Three layouts need care. A four-byte far pointer is split into a 16-bit offset and a 16-bit segment. The stack-frame setup form carries a two-byte field followed by a one-byte field. A single operand byte is widened by sign or by zeros, depending on the operation width and the I/O flag.

Top module: `trail_field_asm`

## Requirements
- R1: In reset and in the first cycle after it, `busy_o`, `in_ready_o`, `done_o` and `bytes_left_o` are 0, and `disp_o` and `opnd_o` are 0.
- R2: Length codes. `disp_len_i` 0/1/2 means 0/1/2 displacement bytes, and code 3 is treated as 2. `opnd_code_i` 0/1/2/3 means 0/1/2/4 operand bytes. In the cycle after an accepted start with a non-zero total, `bytes_left_o` equals the total. It drops by one after each accepted byte (`in_valid_i` high while `in_ready_o` is high). It is 0 whenever the block is idle.
- R3: Stream order is displacement bytes first, then operand bytes. Each multi-byte field takes its first byte as bits 7:0 and its second byte as bits 15:8.
- R4: A one-byte displacement is sign-extended from bit 7 to 16 bits. A two-byte displacement is delivered unchanged as a signed 16-bit value. With no displacement, `disp_o` is 0.
- R5: A one-byte operand is sign-extended when `word_op_i`=1 and `io_op_i`=0, and is zero-extended otherwise. A two-byte operand is delivered unchanged. With no operand, `opnd_o` is 0.
- R6: With `opnd_code_i`=3 (far pointer), `disp_len_i` is ignored and four bytes are taken. The first two bytes form the offset on `disp_o`, and the last two form the segment on `opnd_o`.
- R7: With `disp_len_i`=2 and `opnd_code_i`=1 (frame setup layout), `disp_o` comes from bytes 0 and 1, and `opnd_o` comes from byte 2, widened as in R5.
- R8: `done_o` is high for exactly one cycle: the cycle after the final byte is accepted. In that same cycle `busy_o` and `in_ready_o` are low and the new values are on `disp_o` and `opnd_o`.
- R9: When both lengths are zero, `done_o` is high in the cycle after the start, and no byte is accepted (`in_ready_o` stays low).
- R10: `start_i` has no effect while busy, including in the cycle that accepts the final byte. `in_valid_i` has no effect while idle.
- R11: An accepted start clears `disp_o` and `opnd_o` to 0. Apart from that, they change only at completion, and they hold after it until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a collection with the lengths below |
| disp_len_i | input | 2 | Displacement byte count code |
| opnd_code_i | input | 2 | Operand length code (0, 1, 2 or 4 bytes) |
| word_op_i | input | 1 | Operation width is a word |
| io_op_i | input | 1 | Operation is a port input or output |
| in_valid_i | input | 1 | A stream byte is offered |
| in_byte_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Block accepts a stream byte this cycle |
| busy_o | output | 1 | Collection in progress |
| bytes_left_o | output | 3 | Bytes still needed |
| done_o | output | 1 | One-cycle completion pulse |
| disp_o | output | 16 | Signed displacement or far offset |
| opnd_o | output | 16 | Operand or far segment |

## Verification
The critical coincidence is a new `start_i` landing in the same cycle as the final stream byte. The bench raises `start_i` together with the last `in_valid_i` in half of its transactions. It then checks that the completion pulse and the assembled fields match the finished instruction, and that the following cycle shows an idle block with unchanged fields rather than a fresh collection. Start requests during wait cycles in the middle of a collection, and bytes offered while idle, are judged the same way through `bytes_left_o`, `busy_o` and the held outputs.

// File: rtl/tfa_pkg.sv
// Shared constants and types for the trailing field assembler.
// Assumes byte-wide stream input and 16-bit assembled fields.
package tfa_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 4;
    localparam int FIELD_W   = 16;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int IDX_W     = $clog2(MAX_BYTES);

    typedef enum logic [1:0] {
        OPND_NONE = 2'd0,
        OPND_BYTE = 2'd1,
        OPND_WORD = 2'd2,
        OPND_FAR  = 2'd3
    } opnd_code_e;

    typedef struct packed {
        logic [CNT_W-1:0] disp_n;
        logic [CNT_W-1:0] opnd_n;
        logic [CNT_W-1:0] total;
    } plan_t;
endpackage

// File: rtl/tfa_len_plan.sv
// Turns the length codes into byte counts for each field.
// A far pointer is treated as a two-byte first field plus a two-byte
// second field; the displacement code is then ignored.
module tfa_len_plan
    import tfa_pkg::*;
(
    input  logic [1:0] disp_len_i,
    input  logic [1:0] opnd_code_i,
    output plan_t      plan_o
);
    // Decode the two codes into per-field byte counts and the total.
    always_comb begin
        plan_o = '0;
        unique case (opnd_code_e'(opnd_code_i))
            OPND_FAR: begin
                plan_o.disp_n = CNT_W'(2);
                plan_o.opnd_n = CNT_W'(2);
            end
            default: begin
                case (disp_len_i)
                    2'd0:    plan_o.disp_n = CNT_W'(0);
                    2'd1:    plan_o.disp_n = CNT_W'(1);
                    default: plan_o.disp_n = CNT_W'(2);
                endcase
                case (opnd_code_i)
                    2'd1:    plan_o.opnd_n = CNT_W'(1);
                    2'd2:    plan_o.opnd_n = CNT_W'(2);
                    default: plan_o.opnd_n = CNT_W'(0);
                endcase
            end
        endcase
        plan_o.total = plan_o.disp_n + plan_o.opnd_n;
    end
endmodule

// File: rtl/tfa_byte_store.sv
// Small lane store for incoming stream bytes, addressed by arrival index.
// Exposes a write-through view so the byte arriving this cycle is
// visible to the field extractor in the same cycle.
module tfa_byte_store #(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    wr_en_i,
    input  logic [IDX_W-1:0]        wr_idx_i,
    input  logic [BYTE_W-1:0]       wr_byte_i,
    output logic [DEPTH*BYTE_W-1:0] view_o
);
    logic [BYTE_W-1:0] lane_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_lane
        // Hold one stream byte; cleared at reset and on a new collection.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                lane_q[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                lane_q[g] <= wr_byte_i;
            end
        end

        // Present the stored byte, or the one being written now.
        assign view_o[g*BYTE_W +: BYTE_W] =
            (wr_en_i && (wr_idx_i == IDX_W'(g))) ? wr_byte_i : lane_q[g];
    end
endmodule

// File: rtl/tfa_field_extract.sv
// Splits the stored byte stream into the displacement and the operand.
// The first field starts at byte 0 and the second follows it; both are
// low byte first. The displacement always carries its sign upward. A
// one-byte operand is sign-filled only when asked.
module tfa_field_extract
    import tfa_pkg::*;
(
    input  logic [MAX_BYTES*BYTE_W-1:0] view_i,
    input  logic [CNT_W-1:0]            disp_n_i,
    input  logic [CNT_W-1:0]            opnd_n_i,
    input  logic                        sext_opnd_i,
    output logic [FIELD_W-1:0]          disp_o,
    output logic [FIELD_W-1:0]          opnd_o
);
    localparam int FB = FIELD_W / BYTE_W;

    logic [BYTE_W-1:0] lane [MAX_BYTES];
    logic              dsign;
    logic              osign;

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_unpack
        assign lane[g] = view_i[g*BYTE_W +: BYTE_W];
    end

    // Assemble the displacement field with sign fill above its top byte.
    always_comb begin
        disp_o = '0;
        dsign  = 1'b0;
        if (disp_n_i != '0) begin
            dsign = lane[IDX_W'(disp_n_i - CNT_W'(1))][BYTE_W-1];
        end
        for (int j = 0; j < FB; j++) begin
            if (j < int'(disp_n_i)) begin
                disp_o[j*BYTE_W +: BYTE_W] = lane[j];
            end else begin
                disp_o[j*BYTE_W +: BYTE_W] = {BYTE_W{dsign}};
            end
        end
    end

    // Assemble the operand field from the bytes after the displacement.
    always_comb begin
        opnd_o = '0;
        osign  = 1'b0;
        if ((opnd_n_i == CNT_W'(1)) && sext_opnd_i) begin
            osign = lane[IDX_W'(disp_n_i)][BYTE_W-1];
        end
        for (int j = 0; j < FB; j++) begin
            if ((j < int'(opnd_n_i)) && ((int'(disp_n_i) + j) < MAX_BYTES)) begin
                opnd_o[j*BYTE_W +: BYTE_W] = lane[IDX_W'(int'(disp_n_i) + j)];
            end else begin
                opnd_o[j*BYTE_W +: BYTE_W] = {BYTE_W{osign}};
            end
        end
    end
endmodule

// File: rtl/tfa_seq_ctrl.sv
// Collection sequencer: accepts a start only when idle, counts the
// bytes still owed, steps the write index and pulses completion.
// Assumes the total is at most MAX_BYTES.
module tfa_seq_ctrl
    import tfa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic             byte_valid_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] left_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o,
    output logic             start_acc_o,
    output logic             byte_acc_o,
    output logic             last_o
);
    logic             busy_q;
    logic [CNT_W-1:0] left_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;

    assign start_acc_o = start_i && !busy_q;
    assign byte_acc_o  = byte_valid_i && busy_q;
    assign last_o      = byte_acc_o && (left_q == CNT_W'(1));

    // Advance the collection state on starts and accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_acc_o) begin
                idx_q <= '0;
                if (total_i == '0) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    left_q <= total_i;
                end
            end else if (byte_acc_o) begin
                left_q <= left_q - CNT_W'(1);
                idx_q  <= idx_q + IDX_W'(1);
                if (last_o) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign left_o = left_q;
    assign idx_o  = idx_q;
    assign done_o = done_q;
endmodule

// File: rtl/trail_field_asm.sv
// Trailing field assembler top. It latches the length plan at an accepted
// start, collects stream bytes under valid/ready and registers the
// assembled displacement and operand at completion.
// Assumes the upstream decoder holds the length inputs valid with start_i.
module trail_field_asm
    import tfa_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         disp_len_i,
    input  logic [1:0]         opnd_code_i,
    input  logic               word_op_i,
    input  logic               io_op_i,
    input  logic               in_valid_i,
    input  logic [BYTE_W-1:0]  in_byte_i,
    output logic               in_ready_o,
    output logic               busy_o,
    output logic [CNT_W-1:0]   bytes_left_o,
    output logic               done_o,
    output logic [FIELD_W-1:0] disp_o,
    output logic [FIELD_W-1:0] opnd_o
);
    plan_t                     plan_in;
    plan_t                     plan_q;
    logic                      sext_q;
    logic                      busy;
    logic [CNT_W-1:0]          left;
    logic [IDX_W-1:0]          idx;
    logic                      start_acc;
    logic                      byte_acc;
    logic                      last_byte;
    logic [MAX_BYTES*BYTE_W-1:0] view;
    logic [FIELD_W-1:0]        disp_nx;
    logic [FIELD_W-1:0]        opnd_nx;
    logic [FIELD_W-1:0]        disp_q;
    logic [FIELD_W-1:0]        opnd_q;

    tfa_len_plan u_plan (
        .disp_len_i  (disp_len_i),
        .opnd_code_i (opnd_code_i),
        .plan_o      (plan_in)
    );

    tfa_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .total_i      (plan_in.total),
        .byte_valid_i (in_valid_i),
        .busy_o       (busy),
        .left_o       (left),
        .idx_o        (idx),
        .done_o       (done_o),
        .start_acc_o  (start_acc),
        .byte_acc_o   (byte_acc),
        .last_o       (last_byte)
    );

    tfa_byte_store #(.BYTE_W(BYTE_W), .DEPTH(MAX_BYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_acc),
        .wr_en_i   (byte_acc),
        .wr_idx_i  (idx),
        .wr_byte_i (in_byte_i),
        .view_o    (view)
    );

    tfa_field_extract u_extract (
        .view_i      (view),
        .disp_n_i    (plan_q.disp_n),
        .opnd_n_i    (plan_q.opnd_n),
        .sext_opnd_i (sext_q),
        .disp_o      (disp_nx),
        .opnd_o      (opnd_nx)
    );

    // Capture the length plan and widening rule at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plan_q <= '0;
            sext_q <= 1'b0;
        end else if (start_acc) begin
            plan_q <= plan_in;
            sext_q <= word_op_i && !io_op_i;
        end
    end

    // Clear the result on an accepted start and load it on the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) begin
            disp_q <= '0;
            opnd_q <= '0;
        end else if (last_byte) begin
            disp_q <= disp_nx;
            opnd_q <= opnd_nx;
        end
    end

    assign in_ready_o   = busy;
    assign busy_o       = busy;
    assign bytes_left_o = busy ? left : '0;
    assign disp_o       = disp_q;
    assign opnd_o       = opnd_q;
endmodule

// File: rtl/trail_field_asm_chk.sv
// Protocol and timing checker for the trailing field assembler, bound
// to every instance of the top module.
module trail_field_asm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [1:0]  disp_len_i,
    input logic [1:0]  opnd_code_i,
    input logic        in_valid_i,
    input logic        busy_o,
    input logic [2:0]  bytes_left_o,
    input logic        done_o,
    input logic [15:0] disp_o,
    input logic [15:0] opnd_o
);
    AST_LEFT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> bytes_left_o == 3'd0); // R2
    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_left_o <= 3'd4); // R2
    AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && in_valid_i && bytes_left_o > 3'd1 |=> busy_o && bytes_left_o == $past(bytes_left_o) - 3'd1); // R2
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i && opnd_code_i != 2'd0 |=> busy_o && bytes_left_o != 3'd0 && !done_o); // R2
    AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && in_valid_i && bytes_left_o == 3'd1 |=> done_o && !busy_o); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i && disp_len_i == 2'd0 && opnd_code_i == 2'd0 |=> done_o && !busy_o); // R9
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !in_valid_i |=> busy_o && $stable(bytes_left_o)); // R10
    AST_IDLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i && in_valid_i |=> !busy_o && !done_o); // R10
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i && !(busy_o && in_valid_i && bytes_left_o == 3'd1) |=> $stable(disp_o) && $stable(opnd_o)); // R11
endmodule

bind trail_field_asm trail_field_asm_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .disp_len_i   (disp_len_i),
    .opnd_code_i  (opnd_code_i),
    .in_valid_i   (in_valid_i),
    .busy_o       (busy_o),
    .bytes_left_o (bytes_left_o),
    .done_o       (done_o),
    .disp_o       (disp_o),
    .opnd_o       (opnd_o)
);

// File: tb/trail_field_asm_tb_top.sv
`timescale 1ns/1ps
// Sweep bench: every length code, width and I/O flag, several byte patterns,
// with wait cycles and start collisions; expectations computed here.
module trail_field_asm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  disp_len_i = '0;
    logic [1:0]  opnd_code_i = '0;
    logic        word_op_i = 1'b0;
    logic        io_op_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_byte_i = '0;
    logic        in_ready_o;
    logic        busy_o;
    logic [2:0]  bytes_left_o;
    logic        done_o;
    logic [15:0] disp_o;
    logic [15:0] opnd_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    trail_field_asm dut_i (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One collection: start, optional wait with stray start, bytes, checks.
    task automatic run_txn(input int dl, input int oc, input int w, input int iov,
                           input int seed, input bit gap, input bit collide);
        logic [7:0]  b [4];
        int          dn, on, tot;
        logic [15:0] ed, eo, hd, ho;
        string       rd, ro;
        dn  = (oc == 3) ? 2 : ((dl == 3) ? 2 : dl);
        on  = (oc == 3) ? 2 : ((oc == 0) ? 0 : oc);
        tot = dn + on;
        for (int k = 0; k < 4; k++)
            b[k] = 8'((seed * 83 + k * 57 + dl * 29 + oc * 13 + 49) ^ ((seed & 2) ? 128 : 0));
        ed = (dn == 1) ? {{8{b[0][7]}}, b[0]} : (dn == 2) ? {b[1], b[0]} : 16'h0;
        if (on == 1) eo = (w == 1 && iov == 0) ? {{8{b[dn][7]}}, b[dn]} : {8'h00, b[dn]};
        else if (on == 2) eo = {b[dn + 1], b[dn]};
        else eo = 16'h0;
        rd = (oc == 3) ? "R6" : (dn == 2 && oc == 1) ? "R7" : (dn == 2) ? "R3" : "R4";
        ro = (oc == 3) ? "R6" : (dn == 2 && oc == 1) ? "R7" : (on == 2) ? "R3" : "R5";

        @(negedge clk);
        start_i = 1'b1; disp_len_i = 2'(dl); opnd_code_i = 2'(oc);
        word_op_i = w[0]; io_op_i = iov[0];
        @(negedge clk);
        start_i = 1'b0;
        check("R11", "disp cleared", disp_o, 16'h0);
        check("R11", "opnd cleared", opnd_o, 16'h0);
        if (tot == 0) begin
            check("R9", "done after empty start", done_o, 1);
            check("R9", "ready on empty", in_ready_o, 0);
            @(negedge clk);
            check("R8", "done pulse ends", done_o, 0);
            return;
        end
        check("R2", "left after start", bytes_left_o, tot);
        check("R2", "busy after start", busy_o, 1);
        for (int k = 0; k < tot; k++) begin
            if (gap && k == 1) begin
                start_i = 1'b1; disp_len_i = 2'd0; opnd_code_i = 2'd0;
                @(negedge clk);
                start_i = 1'b0;
                check("R10", "left during stray start", bytes_left_o, tot - 1);
                check("R10", "no done on stray start", done_o, 0);
            end
            in_valid_i = 1'b1; in_byte_i = b[k];
            start_i = collide && (k == tot - 1);
            @(negedge clk);
            in_valid_i = 1'b0; start_i = 1'b0;
            if (k < tot - 1) begin
                check("R2", "left after byte", bytes_left_o, tot - k - 1);
                check("R8", "no early done", done_o, 0);
            end
        end
        check("R8", "done after last", done_o, 1);
        check("R8", "ready low at done", in_ready_o, 0);
        check("R2", "left zero at done", bytes_left_o, 0);
        check(rd, "disp", disp_o, ed);
        check(ro, "opnd", opnd_o, eo);
        hd = disp_o; ho = opnd_o;
        in_valid_i = 1'b1; in_byte_i = 8'hA5;
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R8", "done one cycle", done_o, 0);
        check("R10", "collision start ignored", busy_o, 0);
        check("R10", "idle byte ignored", bytes_left_o, 0);
        @(negedge clk);
        check("R11", "disp held", disp_o, hd);
        check("R11", "opnd held", opnd_o, ho);
        check("R10", "no done from idle byte", done_o, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", busy_o, 0);
        check("R1", "done in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", busy_o, 0);
        check("R1", "ready after reset", in_ready_o, 0);
        check("R1", "left after reset", bytes_left_o, 0);
        check("R1", "done after reset", done_o, 0);
        check("R1", "disp after reset", disp_o, 0);
        check("R1", "opnd after reset", opnd_o, 0);
        for (int dl = 0; dl < 4; dl++)
            for (int oc = 0; oc < 4; oc++)
                for (int w = 0; w < 2; w++)
                    for (int iov = 0; iov < 2; iov++)
                        for (int s = 0; s < 4; s++)
                            run_txn(dl, oc, w, iov, s, s[0], s[1]);
        summary();
        $finish;
    end
endmodule